// File: doc/BRIEF.md
# Little-Endian Load/Store Unit

This unit carries out the memory half of load and store instructions for a 32-bit core. When an instruction is issued, it forms the effective byte address in one of two ways: a base register plus a zero-extended 12-bit offset, or a base register plus an index register. It then drives one request to a 32-bit little-endian data memory. For that request it produces the byte-enable lanes and the store data, and it returns the load result to the register file.

A transfer starts with a one-cycle `start_i` pulse, with the operand values presented in the same cycle. One cycle later the unit drives a single-cycle memory request. The memory answers one cycle after the request, and `done_o` pulses in the cycle after that. A half-word access at an odd address, or a word access whose address is not a multiple of four, is rejected: in that case the error flag pulses together with `done_o` and memory is never touched.

Top module: `lsu_top`

## Requirements
- R1: With `use_index_i`=0, the address is `base_i` plus `offset_i` zero-extended (offset 0xFFC on base 4 gives 0x1000), taken modulo 2^32.
- R2: With `use_index_i`=1, the address is `base_i` plus `index_i` modulo 2^32 (0xFFFFFFFC + 8 gives 4).
- R3: `size_i` encodes 0=byte, 1=half-word, 2=word. While a request is out, `mem_be_o` bit i enables byte lane i (bits 8i+7:8i). A byte access enables lane addr[1:0]. A half-word enables 0011 when addr[1]=0 and 1100 when it is 1. A word enables 1111.
- R4: For a store, a byte puts target bits 7:0 into all four lanes, a half-word puts bits 15:0 into both halves, and a word sends the full target value. `mem_we_o`=1 only for stores.
- R5: For a load, `load_data_o` is the enabled lanes of the memory word shifted down to bit 0 and zero-extended.
- R6: A half-word access at an odd address, a word access with addr[1:0]≠0, or a size code of 3 raises `err_o` and `done_o` together for one cycle, in the cycle after start, and issues no memory request.
- R7: An accepted transfer drives `mem_req_o` for exactly one cycle, in the cycle after start. `done_o` is high for one cycle, two cycles after the request.
- R8: A `start_i` that arrives while a transfer is in progress is ignored and issues no request.
- R9: After reset, `mem_req_o`, `mem_we_o`, `mem_be_o`, `done_o`, `err_o` and `load_data_o` are all zero.
- R10: `load_data_o` changes only when a load completes. Stores and errors leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a transfer with the operands below |
| is_store_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | 0 byte, 1 half-word, 2 word |
| use_index_i | input | 1 | 1 = base+index, 0 = base+offset |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| offset_i | input | 12 | Unsigned offset |
| target_i | input | 32 | Target register value (store source) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write request |
| mem_addr_o | output | 32 | Byte address |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Write data by lane |
| mem_rdata_i | input | 32 | Read word, valid one cycle after the request |
| load_data_o | output | 32 | Zero-extended load result |
| done_o | output | 1 | Transfer finished |
| err_o | output | 1 | Misaligned or illegal size |

## Verification
Take the start pulse as sampled at clock edge k. The request and its address, lanes and write data then appear just after edge k, and an alignment error with its done pulse appears at that same point. Memory captures or returns data at edge k+1. Done and the load result become visible after edge k+2. The bench drives inputs and samples outputs on falling edges, and it checks each result exactly in the cycle it is due. It also checks that the request and the error have dropped again one cycle later.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    parameter int XLEN  = 32;
    parameter int NBYTE = XLEN / 8;
    parameter int LOW_W = $clog2(NBYTE);

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } lsu_state_e;

    typedef struct packed {
        lsu_state_e        st;
        logic              req;
        logic              we;
        logic [XLEN-1:0]   addr;
        logic [NBYTE-1:0]  be;
        logic [XLEN-1:0]   wdata;
        logic [1:0]        size;
        logic              done;
        logic              err;
        logic [XLEN-1:0]   ldata;
    } lsu_regs_t;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
    parameter int XLEN  = 32,
    parameter int OFS_W = 12
) (
    input  logic             use_index,
    input  logic [XLEN-1:0]  base,
    input  logic [XLEN-1:0]  index,
    input  logic [OFS_W-1:0] offset,
    input  logic [1:0]       size,
    output logic [XLEN-1:0]  addr,
    output logic             misaligned
);
    import lsu_pkg::*;

    logic [XLEN-1:0] addend;

    always_comb begin
        addend = use_index ? index : {{(XLEN-OFS_W){1'b0}}, offset};
        addr   = base + addend;
        case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = addr[0];
            SZ_WORD: misaligned = |addr[1:0];
            default: misaligned = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
    parameter int XLEN = 32,
    localparam int NB  = XLEN / 8,
    localparam int LW  = $clog2(NB)
) (
    input  logic [1:0]      size,
    input  logic [LW-1:0]   low,
    input  logic [XLEN-1:0] src,
    output logic [NB-1:0]   be,
    output logic [XLEN-1:0] wdata
);
    import lsu_pkg::*;

    logic [XLEN-1:0] rep_byte;
    logic [XLEN-1:0] rep_half;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_byte_rep
            assign rep_byte[g*8 +: 8] = src[7:0];
        end
        for (g = 0; g < NB/2; g++) begin : g_half_rep
            assign rep_half[g*16 +: 16] = src[15:0];
        end
    endgenerate

    always_comb begin
        case (size)
            SZ_BYTE: begin
                be    = NB'(1) << low;
                wdata = rep_byte;
            end
            SZ_HALF: begin
                be    = NB'(3) << {low[LW-1:1], 1'b0};
                wdata = rep_half;
            end
            default: begin
                be    = '1;
                wdata = src;
            end
        endcase
    end
endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane #(
    parameter int XLEN = 32,
    localparam int NB  = XLEN / 8,
    localparam int LW  = $clog2(NB)
) (
    input  logic [1:0]      size,
    input  logic [LW-1:0]   low,
    input  logic [XLEN-1:0] rword,
    output logic [XLEN-1:0] value
);
    import lsu_pkg::*;

    logic [XLEN-1:0] shifted;

    always_comb begin
        shifted = rword >> {low, 3'b000};
        case (size)
            SZ_BYTE: value = {{(XLEN-8){1'b0}}, shifted[7:0]};
            SZ_HALF: value = {{(XLEN-16){1'b0}}, shifted[15:0]};
            default: value = rword;
        endcase
    end
endmodule

// File: rtl/lsu_top.sv
module lsu_top #(
    parameter int OFS_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       is_store_i,
    input  logic [1:0]                 size_i,
    input  logic                       use_index_i,
    input  logic [lsu_pkg::XLEN-1:0]   base_i,
    input  logic [lsu_pkg::XLEN-1:0]   index_i,
    input  logic [OFS_W-1:0]           offset_i,
    input  logic [lsu_pkg::XLEN-1:0]   target_i,
    output logic                       mem_req_o,
    output logic                       mem_we_o,
    output logic [lsu_pkg::XLEN-1:0]   mem_addr_o,
    output logic [lsu_pkg::NBYTE-1:0]  mem_be_o,
    output logic [lsu_pkg::XLEN-1:0]   mem_wdata_o,
    input  logic [lsu_pkg::XLEN-1:0]   mem_rdata_i,
    output logic [lsu_pkg::XLEN-1:0]   load_data_o,
    output logic                       done_o,
    output logic                       err_o
);
    import lsu_pkg::*;

    lsu_regs_t q, d;

    logic [XLEN-1:0]  ea;
    logic             misal;
    logic [NBYTE-1:0] be_n;
    logic [XLEN-1:0]  wd_n;
    logic [XLEN-1:0]  ld_val;

    lsu_agen #(.XLEN(XLEN), .OFS_W(OFS_W)) u_agen (
        .use_index  (use_index_i),
        .base       (base_i),
        .index      (index_i),
        .offset     (offset_i),
        .size       (size_i),
        .addr       (ea),
        .misaligned (misal)
    );

    lsu_store_lane #(.XLEN(XLEN)) u_st (
        .size  (size_i),
        .low   (ea[LOW_W-1:0]),
        .src   (target_i),
        .be    (be_n),
        .wdata (wd_n)
    );

    lsu_load_lane #(.XLEN(XLEN)) u_ld (
        .size  (q.size),
        .low   (q.addr[LOW_W-1:0]),
        .rword (mem_rdata_i),
        .value (ld_val)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (misal) begin
                        d.err  = 1'b1;
                        d.done = 1'b1;
                    end else begin
                        d.st    = ST_REQ;
                        d.req   = 1'b1;
                        d.we    = is_store_i;
                        d.addr  = ea;
                        d.be    = be_n;
                        d.wdata = is_store_i ? wd_n : '0;
                        d.size  = size_i;
                    end
                end
            end
            ST_REQ: begin
                d.req = 1'b0;
                d.st  = ST_WAIT;
            end
            ST_WAIT: begin
                d.done = 1'b1;
                if (!q.we) d.ldata = ld_val;
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_req_o   = q.req;
    assign mem_we_o    = q.req & q.we;
    assign mem_addr_o  = q.addr;
    assign mem_be_o    = q.req ? q.be : '0;
    assign mem_wdata_o = q.wdata;
    assign load_data_o = q.ldata;
    assign done_o      = q.done;
    assign err_o       = q.err;

    a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);
    a_r7_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> ##1 done_o);
    a_r6_err_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && !mem_req_o));
    a_r3_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2
                       || $countones(mem_be_o) == NBYTE));
    a_r8_busy_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> !mem_req_o);
    a_r10_ldata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_data_o != $past(load_data_o)) |-> done_o);
endmodule

// File: tb/tb_lsu_top.sv
module tb_lsu_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i, is_store_i, use_index_i;
    logic [1:0]  size_i;
    logic [31:0] base_i, index_i, target_i;
    logic [11:0] offset_i;
    logic        mem_req_o, mem_we_o, done_o, err_o;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, load_data_o;
    logic [3:0]  mem_be_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    logic [31:0] mem [16];

    always #10 clk = ~clk;

    lsu_top dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_store_i(is_store_i),
        .size_i(size_i), .use_index_i(use_index_i), .base_i(base_i),
        .index_i(index_i), .offset_i(offset_i), .target_i(target_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .load_data_o(load_data_o), .done_o(done_o), .err_o(err_o)
    );

    always @(posedge clk) begin
        if (mem_req_o) begin
            if (mem_we_o) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be_o[b]) mem[mem_addr_o[5:2]][b*8 +: 8] <= mem_wdata_o[b*8 +: 8];
            end else begin
                mem_rdata_i <= mem[mem_addr_o[5:2]];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input bit st, input logic [1:0] sz, input bit ux,
                         input logic [31:0] b, input logic [31:0] ix,
                         input logic [11:0] of, input logic [31:0] tv);
        @(negedge clk);
        start_i = 1'b1; is_store_i = st; size_i = sz; use_index_i = ux;
        base_i = b; index_i = ix; offset_i = of; target_i = tv;
    endtask

    task automatic run_op(input string tag, input bit st, input logic [1:0] sz, input bit ux,
                          input logic [31:0] b, input logic [31:0] ix, input logic [11:0] of,
                          input logic [31:0] tv, input logic [31:0] e_addr, input logic [3:0] e_be,
                          input logic [31:0] e_wd, input logic [31:0] e_ld);
        drive(st, sz, ux, b, ix, of, tv);
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " R7 req"}, 32'(mem_req_o), 32'd1);
        chk({tag, " R4 we"}, 32'(mem_we_o), 32'(st));
        chk({tag, " R1/R2 addr"}, mem_addr_o, e_addr);
        chk({tag, " R3 be"}, 32'(mem_be_o), 32'(e_be));
        if (st) chk({tag, " R4 wdata"}, mem_wdata_o, e_wd);
        @(negedge clk);
        chk({tag, " R7 req drop"}, 32'(mem_req_o), 32'd0);
        chk({tag, " R7 no early done"}, 32'(done_o), 32'd0);
        @(negedge clk);
        chk({tag, " R7 done"}, 32'(done_o), 32'd1);
        chk({tag, " R6 no err"}, 32'(err_o), 32'd0);
        chk({tag, " R5/R10 load data"}, load_data_o, e_ld);
        @(negedge clk);
        chk({tag, " R7 done single"}, 32'(done_o), 32'd0);
    endtask

    task automatic t_misalign(input string tag, input logic [1:0] sz, input logic [31:0] b,
                              input logic [11:0] of, input logic [31:0] hold_ld);
        drive(1'b0, sz, 1'b0, b, 32'd0, of, 32'd0);
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " R6 err"}, 32'(err_o), 32'd1);
        chk({tag, " R6 done"}, 32'(done_o), 32'd1);
        chk({tag, " R6 no req"}, 32'(mem_req_o), 32'd0);
        @(negedge clk);
        chk({tag, " R6 err single"}, 32'(err_o), 32'd0);
        chk({tag, " R6 still no req"}, 32'(mem_req_o), 32'd0);
        chk({tag, " R10 ldata kept"}, load_data_o, hold_ld);
    endtask

    task automatic t_busy();
        drive(1'b0, 2'd2, 1'b0, 32'd0, 32'd0, 12'd4, 32'd0);
        @(negedge clk);
        chk("busy R7 req", 32'(mem_req_o), 32'd1);
        offset_i = 12'h010;
        @(negedge clk);
        chk("busy R8 no req in wait", 32'(mem_req_o), 32'd0);
        @(negedge clk);
        start_i = 1'b0;
        chk("busy R7 done", 32'(done_o), 32'd1);
        chk("busy R8 no req at done", 32'(mem_req_o), 32'd0);
        chk("busy R5 data", load_data_o, 32'h89ABCDEF);
        @(negedge clk);
        chk("busy R8 nothing issued", 32'(mem_req_o), 32'd0);
        chk("busy R8 no second done", 32'(done_o), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        rst_n = 1'b0; start_i = 0; is_store_i = 0; size_i = 0; use_index_i = 0;
        base_i = 0; index_i = 0; offset_i = 0; target_i = 0;
        repeat (3) @(negedge clk);
        chk("R9 req", 32'(mem_req_o), 0);
        chk("R9 we", 32'(mem_we_o), 0);
        chk("R9 be", 32'(mem_be_o), 0);
        chk("R9 done", 32'(done_o), 0);
        chk("R9 err", 32'(err_o), 0);
        chk("R9 ldata", load_data_o, 0);
        rst_n = 1'b1;

        run_op("st8", 1, 2'd0, 0, 32'h10, 0, 12'd3, 32'h123456AB, 32'h13, 4'b1000, 32'hABABABAB, 32'h0);
        run_op("ld8", 0, 2'd0, 0, 32'h10, 0, 12'd3, 0, 32'h13, 4'b1000, 0, 32'h000000AB);
        run_op("st16", 1, 2'd1, 1, 32'h20, 32'h2, 0, 32'hCAFEBEEF, 32'h22, 4'b1100, 32'hBEEFBEEF, 32'hAB);
        run_op("ld16", 0, 2'd1, 1, 32'h20, 32'h2, 0, 0, 32'h22, 4'b1100, 0, 32'h0000BEEF);
        run_op("ld32 upper half", 0, 2'd2, 0, 32'h20, 0, 0, 0, 32'h20, 4'b1111, 0, 32'hBEEF0000);
        run_op("st32 R2 wrap", 1, 2'd2, 1, 32'hFFFFFFFC, 32'h8, 0, 32'h89ABCDEF, 32'h4, 4'b1111, 32'h89ABCDEF, 32'hBEEF0000);
        run_op("ld32", 0, 2'd2, 0, 32'h0, 0, 12'd4, 0, 32'h4, 4'b1111, 0, 32'h89ABCDEF);
        run_op("ld8 lane1", 0, 2'd0, 0, 32'h4, 0, 12'd1, 0, 32'h5, 4'b0010, 0, 32'h000000CD);
        run_op("ld16 low", 0, 2'd1, 0, 32'h4, 0, 12'd0, 0, 32'h4, 4'b0011, 0, 32'h0000CDEF);
        run_op("st32 R1 large offset", 1, 2'd2, 0, 32'h4, 0, 12'hFFC, 32'h5A5A1234, 32'h1000, 4'b1111, 32'h5A5A1234, 32'h0000CDEF);
        run_op("ld8 after large", 0, 2'd0, 0, 32'h1000, 0, 12'd1, 0, 32'h1001, 4'b0010, 0, 32'h00000012);
        run_op("st8 R10 keep", 1, 2'd0, 0, 32'h30, 0, 12'd0, 32'h77, 32'h30, 4'b0001, 32'h77777777, 32'h00000012);

        t_misalign("half odd", 2'd1, 32'h20, 12'd1, 32'h12);
        t_misalign("word off2", 2'd2, 32'h20, 12'd2, 32'h12);
        t_misalign("size3", 2'd3, 32'h20, 12'd0, 32'h12);
        t_busy();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule